// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds two direction predictors of its own and a chooser between them. The local predictor keeps one 2-bit saturating counter for each branch address slot. The global predictor keeps a second table of 2-bit counters. That table is indexed by the branch address XORed with a shift register of the latest resolved outcomes. A third table of 2-bit counters, indexed by branch address, decides per branch which of the two answers becomes the final prediction.

Fetch logic presents a branch address on the lookup port. In the same cycle, without a clock edge, it receives the final direction, which component was chosen, and both component answers. When the branch resolves, the pipeline presents the address, the real outcome and the two component answers it saw at lookup on the update port. All tables and the history register change on the following clock edge. History moves only at resolution, so a lookup and its later update see the same history as long as no other branch resolves between them.

Top module: `tourn_predictor`

## Requirements
- R1: `lk_local` is the MSB of the local counter selected by `lk_pc[IDX_W-1:0]` (256 entries by default). A counter value of 2 or 3 means taken.
- R2: `lk_global` is the MSB of the global counter selected by `lk_pc[IDX_W-1:0]` XOR the history register.
- R3: On every clock with `up_valid` high, the history register shifts left by one and takes `up_taken` into bit 0 (1 = taken). With `up_valid` low it holds. History is never changed at lookup.
- R4: `lk_use_global` is 1 when the chooser entry at `lk_pc[IDX_W-1:0]` is 2 or 3. `lk_taken` equals `lk_global` when `lk_use_global` is 1 and `lk_local` otherwise.
- R5: Each valid update moves the addressed local counter and the addressed global counter one step toward the outcome, saturating at 0 and 3.
- R6: The chooser entry at `up_pc[IDX_W-1:0]` steps up (toward global) when only `up_global_pred` matched the outcome. It steps down (toward local) when only `up_local_pred` matched. It saturates at 0 and 3 and is unchanged when both or neither matched.
- R7: After synchronous active-high reset, every counter is 1 (weak not-taken), every chooser is 1 (weak local) and history is 0. Every lookup therefore returns not-taken from the local component.
- R8: A lookup returns table contents from before an update in the same cycle. The update is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | PC_W (32) | Branch address to predict |
| lk_taken | output | 1 | Final predicted direction |
| lk_use_global | output | 1 | 1 when the global component was chosen |
| lk_local | output | 1 | Local component prediction |
| lk_global | output | 1 | Global component prediction |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | PC_W (32) | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| up_local_pred | input | 1 | Local prediction seen at lookup |
| up_global_pred | input | 1 | Global prediction seen at lookup |

## Verification
The bench drives a stream in which one branch copies the random outcome of the branch before it, and another branch is almost always taken. It checks that the chooser ends up on the global component for the first and stays on the local component for the second. A chooser that learned from agreeing answers, or that stepped the wrong way, would leave the correlated branch on the local side. Directed updates with forced agree and disagree predictions test the hold case of the chooser. A counter with no saturation would wrap from 3 to 0 and predict not-taken after a run of taken outcomes. A history register that shifted from the wrong end, or that moved on idle cycles, would make the per-cycle global prediction drift away from the reference model.

// File: rtl/tp_pkg.sv
package tp_pkg;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_WEAK_NT  = 2'd1;
    localparam ctr2_t CHS_WEAK_LCL = 2'd1;

    typedef enum logic [1:0] {
        VOTE_HOLD   = 2'd0,
        VOTE_LOCAL  = 2'd1,
        VOTE_GLOBAL = 2'd2
    } vote_e;

    typedef struct packed {
        logic lcl;
        logic gbl;
        logic use_gbl;
        logic final_dir;
    } pred_t;

    // one saturating step toward the observed direction
    function automatic ctr2_t ctr_train(ctr2_t c, logic dir_taken);
        ctr2_t n;
        if (dir_taken) n = (c == 2'd3) ? c : c + 2'd1;
        else           n = (c == 2'd0) ? c : c - 2'd1;
        return n;
    endfunction

    // which component earned credit on this resolution
    function automatic vote_e judge(logic lp, logic gp, logic outcome);
        vote_e v;
        if (lp == gp)           v = VOTE_HOLD;
        else if (gp == outcome) v = VOTE_GLOBAL;
        else                    v = VOTE_LOCAL;
        return v;
    endfunction

    function automatic ctr2_t chooser_step(ctr2_t c, vote_e v);
        ctr2_t n;
        case (v)
            VOTE_GLOBAL: n = ctr_train(c, 1'b1);
            VOTE_LOCAL:  n = ctr_train(c, 1'b0);
            default:     n = c;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/tp_counter_table.sv
module tp_counter_table
    import tp_pkg::*;
#(
    parameter int    IDX_W = 8,
    parameter ctr2_t INIT  = CTR_WEAK_NT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_a_idx,
    output ctr2_t            rd_a_val,
    input  logic [IDX_W-1:0] rd_b_idx,
    output ctr2_t            rd_b_val,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  ctr2_t            wr_val
);
    localparam int DEPTH = 1 << IDX_W;

    ctr2_t cells [DEPTH];

    genvar e;
    generate
        for (e = 0; e < DEPTH; e++) begin : g_cell
            ctr2_t cell_q;
            always_ff @(posedge clk) begin
                if (rst)
                    cell_q <= INIT;
                else if (wr_en && (wr_idx == IDX_W'(e)))
                    cell_q <= wr_val;
            end
            assign cells[e] = cell_q;
        end
    endgenerate

    assign rd_a_val = cells[rd_a_idx];
    assign rd_b_val = cells[rd_b_idx];

    // checker state: the entry written last cycle and its prior value
    logic             chk_vld;
    logic [IDX_W-1:0] chk_idx;
    ctr2_t            chk_old;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_vld <= 1'b0;
            chk_idx <= '0;
            chk_old <= INIT;
        end else begin
            chk_vld <= wr_en;
            chk_idx <= wr_idx;
            chk_old <= cells[wr_idx];
        end
    end

    int step_diff;
    assign step_diff = int'(cells[chk_idx]) - int'(chk_old);

    assert_single_step_R5: assert property (@(posedge clk) disable iff (rst)
        chk_vld |-> (step_diff <= 1 && step_diff >= -1));

endmodule

// File: rtl/tp_ghist.sv
module tp_ghist #(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist
);
    always_ff @(posedge clk) begin
        if (rst)           hist <= '0;
        else if (shift_en) hist <= {hist[HIST_W-2:0], bit_in};
    end

    assert_hist_newest_R3: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (hist[0] == $past(bit_in)));

    assert_hist_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(hist));

endmodule

// File: rtl/tourn_predictor.sv
module tourn_predictor
    import tp_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int IDX_W  = 8,
    parameter int HIST_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    output logic            lk_use_global,
    output logic            lk_local,
    output logic            lk_global,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken,
    input  logic            up_local_pred,
    input  logic            up_global_pred
);
    logic [HIST_W-1:0] ghist;
    logic [IDX_W-1:0]  hist_fold;

    generate
        if (HIST_W >= IDX_W) begin : g_fold_trunc
            assign hist_fold = ghist[IDX_W-1:0];
        end else begin : g_fold_pad
            assign hist_fold = {{(IDX_W-HIST_W){1'b0}}, ghist};
        end
    endgenerate

    logic [IDX_W-1:0] lk_lidx, lk_gidx, up_lidx, up_gidx;
    assign lk_lidx = lk_pc[IDX_W-1:0];
    assign lk_gidx = lk_pc[IDX_W-1:0] ^ hist_fold;
    assign up_lidx = up_pc[IDX_W-1:0];
    assign up_gidx = up_pc[IDX_W-1:0] ^ hist_fold;

    ctr2_t loc_lk, loc_up, gsh_lk, gsh_up, chs_lk, chs_up;
    ctr2_t loc_nxt, gsh_nxt, chs_nxt;
    vote_e vote;
    logic  chs_we;

    assign vote    = judge(up_local_pred, up_global_pred, up_taken);
    assign loc_nxt = ctr_train(loc_up, up_taken);
    assign gsh_nxt = ctr_train(gsh_up, up_taken);
    assign chs_nxt = chooser_step(chs_up, vote);
    assign chs_we  = up_valid && (vote != VOTE_HOLD);

    tp_counter_table #(.IDX_W(IDX_W), .INIT(CTR_WEAK_NT)) u_local (
        .clk(clk), .rst(rst),
        .rd_a_idx(lk_lidx), .rd_a_val(loc_lk),
        .rd_b_idx(up_lidx), .rd_b_val(loc_up),
        .wr_en(up_valid), .wr_idx(up_lidx), .wr_val(loc_nxt)
    );

    tp_counter_table #(.IDX_W(IDX_W), .INIT(CTR_WEAK_NT)) u_gshare (
        .clk(clk), .rst(rst),
        .rd_a_idx(lk_gidx), .rd_a_val(gsh_lk),
        .rd_b_idx(up_gidx), .rd_b_val(gsh_up),
        .wr_en(up_valid), .wr_idx(up_gidx), .wr_val(gsh_nxt)
    );

    tp_counter_table #(.IDX_W(IDX_W), .INIT(CHS_WEAK_LCL)) u_chooser (
        .clk(clk), .rst(rst),
        .rd_a_idx(lk_lidx), .rd_a_val(chs_lk),
        .rd_b_idx(up_lidx), .rd_b_val(chs_up),
        .wr_en(chs_we), .wr_idx(up_lidx), .wr_val(chs_nxt)
    );

    tp_ghist #(.HIST_W(HIST_W)) u_hist (
        .clk(clk), .rst(rst),
        .shift_en(up_valid), .bit_in(up_taken),
        .hist(ghist)
    );

    pred_t pr;
    always_comb begin
        pr.lcl       = loc_lk[1];
        pr.gbl       = gsh_lk[1];
        pr.use_gbl   = chs_lk[1];
        pr.final_dir = pr.use_gbl ? pr.gbl : pr.lcl;
    end

    assign lk_local      = pr.lcl;
    assign lk_global     = pr.gbl;
    assign lk_use_global = pr.use_gbl;
    assign lk_taken      = pr.final_dir;

    assert_reset_state_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!lk_local && !lk_global && !lk_use_global && !lk_taken));

    assert_final_source_R4: assert property (@(posedge clk) disable iff (rst)
        (lk_local == lk_global) |-> (lk_taken == lk_local));

endmodule

// File: tb/tourn_predictor_test.sv
module tourn_predictor_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] lk_pc = '0;
    logic        lk_taken, lk_use_global, lk_local, lk_global;
    logic        up_valid = 1'b0;
    logic [31:0] up_pc = '0;
    logic        up_taken = 1'b0, up_local_pred = 1'b0, up_global_pred = 1'b0;

    always #5 clk = ~clk;

    tourn_predictor uut (
        .clk(clk), .rst(rst), .lk_pc(lk_pc),
        .lk_taken(lk_taken), .lk_use_global(lk_use_global),
        .lk_local(lk_local), .lk_global(lk_global),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
        .up_local_pred(up_local_pred), .up_global_pred(up_global_pred)
    );

    int tests = 0, fails = 0;
    bit done = 0;

    // behavioural reference
    int m_loc [256];
    int m_gsh [256];
    int m_chs [256];
    int m_hist = 0;
    int lfsr = 32'h1ACE5;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 256; i++) begin
            m_loc[i] = 1; m_gsh[i] = 1; m_chs[i] = 1;
        end
        m_hist = 0;
    endtask

    // compare all lookup outputs against the model for the current lk_pc
    task automatic compare_now(input logic [31:0] pc);
        int li, gi, el, eg, eu, et;
        li = pc & 255;
        gi = (pc ^ m_hist) & 255;
        el = (m_loc[li] >= 2);
        eg = (m_gsh[gi] >= 2);
        eu = (m_chs[li] >= 2);
        et = eu ? eg : el;
        check(lk_local == el, "R1 R8 local", lk_local, el);
        check(lk_global == eg, "R2 R3 global", lk_global, eg);
        check(lk_use_global == eu, "R4 chooser", lk_use_global, eu);
        check(lk_taken == et, "R4 final", lk_taken, et);
    endtask

    task automatic model_update(input logic [31:0] pc, input int t, input int lp, input int gp);
        int li, gi;
        li = pc & 255;
        gi = (pc ^ m_hist) & 255;
        m_loc[li] = t ? (m_loc[li] < 3 ? m_loc[li] + 1 : 3) : (m_loc[li] > 0 ? m_loc[li] - 1 : 0);
        m_gsh[gi] = t ? (m_gsh[gi] < 3 ? m_gsh[gi] + 1 : 3) : (m_gsh[gi] > 0 ? m_gsh[gi] - 1 : 0);
        if (lp != gp) begin
            if (gp == t) m_chs[li] = (m_chs[li] < 3) ? m_chs[li] + 1 : 3;
            else         m_chs[li] = (m_chs[li] > 0) ? m_chs[li] - 1 : 0;
        end
        m_hist = ((m_hist << 1) | t) & 255;
    endtask

    // lookup and resolve the same branch in one cycle
    task automatic branch(input logic [31:0] pc, input bit t);
        int lp, gp;
        @(negedge clk);
        lk_pc = pc; up_valid = 1'b0;
        #1;
        compare_now(pc);
        lp = lk_local; gp = lk_global;
        up_valid = 1'b1; up_pc = pc; up_taken = t;
        up_local_pred = lk_local; up_global_pred = lk_global;
        @(posedge clk);
        model_update(pc, t, lp, gp);
    endtask

    // resolution with forced component predictions
    task automatic forced(input logic [31:0] pc, input bit t, input bit lp, input bit gp);
        @(negedge clk);
        lk_pc = pc; up_valid = 1'b1; up_pc = pc; up_taken = t;
        up_local_pred = lp; up_global_pred = gp;
        #1;
        compare_now(pc);
        @(posedge clk);
        model_update(pc, t, lp, gp);
    endtask

    task automatic idle_peek(input logic [31:0] pc);
        @(negedge clk);
        up_valid = 1'b0; lk_pc = pc;
        #1;
        compare_now(pc);
    endtask

    function automatic bit rnd_bit();
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4BCD35C : 0);
        return lfsr[0];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R7: reset state seen through lookups
        check(!lk_local && !lk_global && !lk_use_global && !lk_taken, "R7 reset pc0",
              {lk_local, lk_global, lk_use_global, lk_taken}, 0);
        lk_pc = 32'h0000_00F7;
        #1;
        check(!lk_local && !lk_global && !lk_use_global && !lk_taken, "R7 reset pcF7",
              {lk_local, lk_global, lk_use_global, lk_taken}, 0);
        idle_peek(32'h55);

        // R6 directed chooser behaviour at pc 0x33
        forced(32'h33, 1, 0, 1);
        idle_peek(32'h33);
        check(lk_use_global == 1, "R6 global-only correct steps up", lk_use_global, 1);
        forced(32'h33, 0, 0, 0);
        idle_peek(32'h33);
        check(lk_use_global == 1, "R6 both correct holds", lk_use_global, 1);
        forced(32'h33, 0, 1, 1);
        idle_peek(32'h33);
        check(lk_use_global == 1, "R6 both wrong holds", lk_use_global, 1);
        forced(32'h33, 0, 0, 1);
        idle_peek(32'h33);
        check(lk_use_global == 0, "R6 local-only correct steps down", lk_use_global, 0);

        // R5 saturation on the local counter at pc 0x20
        for (int i = 0; i < 5; i++) branch(32'h20, 1);
        branch(32'h20, 0);
        idle_peek(32'h20);
        check(lk_local == 1, "R5 saturated at 3 then one step down", lk_local, 1);
        branch(32'h20, 0);
        idle_peek(32'h20);
        check(lk_local == 0, "R5 second step reaches not-taken", lk_local, 0);

        // R3 idle cycles leave history alone (model history unchanged)
        repeat (4) idle_peek(32'h84);

        // correlated stream: C copies B, A almost always taken
        for (int it = 0; it < 400; it++) begin
            bit r;
            r = rnd_bit();
            branch(32'h40, r);
            branch(32'h84, r);
            branch(32'h10, (it % 37) != 5);
        end
        idle_peek(32'h84);
        check(lk_use_global == 1, "R6 correlated branch picks global", lk_use_global, 1);
        idle_peek(32'h10);
        check(lk_use_global == 0, "R6 biased branch stays local", lk_use_global, 0);

        // R8: lookup and update of the same entry in one cycle
        @(negedge clk);
        lk_pc = 32'h99; up_valid = 1'b1; up_pc = 32'h99; up_taken = 1;
        up_local_pred = 0; up_global_pred = 1;
        #1;
        check(lk_use_global == 0 && lk_local == 0, "R8 same-cycle lookup sees old state",
              {lk_use_global, lk_local}, 0);
        @(posedge clk);
        model_update(32'h99, 1, 0, 1);
        idle_peek(32'h99);
        check(lk_use_global == 1, "R8 update visible next cycle", lk_use_global, 1);

        @(negedge clk);
        up_valid = 1'b0;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule